// File: doc/BRIEF.md
# Up-Down PWM Pair with Deterministic Trip Recovery

This block generates two complementary-phase pulse outputs from one symmetric up-down time-base counter. The counter climbs from zero to a programmable period and falls back to zero, over and over. A single compare value is matched against it. Output A is switched on by a match seen on the rising slope, and output B by a match seen on the falling slope. This places the A pulse in the first half of each carrier cycle and the B pulse in the second half.

A one-shot trip input forces both outputs low and latches that state. Software can ask for the latch to be cleared at any moment. The block does not obey that request at once. It holds the request pending and releases the latch only when the counter sits at zero at the start of a rising slope, so the first pulse after recovery always comes from output A. The counter can be paused, loaded with a phase value by a sync pulse, or written directly. Each output also has a software force path.

Top module: `updown_pwm_trip`

## Requirements
- R1: When enabled and not loaded, the counter steps +1 while rising and -1 while falling. The flag `cnt_down` is 0 while rising and 1 while falling. The flag reads 1 in the cycle the counter equals the period and 0 in the cycle it returns to 0. With period P ≥ 1 the sequence is 0,1,…,P,P-1,…,1,0,1,…. A period of 0 holds the counter at 0.
- R2: Output A goes to 1 on the edge after a cycle where the counter equals the compare value with `cnt_down`=0, and goes to 0 on the edge after a cycle where the counter equals the period. Output B goes to 1 after a compare match with `cnt_down`=1, and goes to 0 after a cycle where the counter equals 0. If a set and a clear hit the same cycle, the clear wins. Between events each output holds its level.
- R3: While `tb_en` is 0 (and no sync or write), the counter and its direction hold. When `tb_en` returns, counting resumes from the held value; the phase value is not reloaded.
- R4: A sync pulse (`sync_ext` or `sync_sw` high at an edge) loads the counter with `phase` and sets the direction to rising, whether or not `tb_en` is high.
- R5: With `cnt_wr` high at an edge, the counter takes `cnt_wdata` and keeps its direction. If a sync pulse occurs in the same cycle, the sync pulse wins.
- R6: `trip_in` high at an edge sets the trip latch (`tripped`=1) and drives both outputs to 0 at that edge. The latch stays set until released as in R7.
- R7: `trip_clr` high while latched arms a pending release. The latch falls on the first later edge where the counter was 0 with `cnt_down`=0, and never at any other counter value. Outputs stay 0 through the releasing edge.
- R8: A `trip_in` at an edge cancels any pending release, including a `trip_clr` given in the same cycle. The latch then stays set past the next zero point.
- R9: With force enabled on an output, that output takes its force level at the next edge, overriding compare actions. The trip state overrides force.
- R10: After a release, the first output to rise is A whenever the compare value lies in 1..P-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | Time-base count enable |
| period | input | CNT_W | Counter top value |
| cmp | input | CNT_W | Compare value shared by A and B |
| phase | input | CNT_W | Value loaded by a sync pulse |
| sync_ext | input | 1 | External sync pulse |
| sync_sw | input | 1 | Software sync pulse |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_wdata | input | CNT_W | Direct counter write value |
| trip_in | input | 1 | One-shot trip event |
| trip_clr | input | 1 | Request to release the trip latch |
| frc_a_en | input | 1 | Force enable for output A |
| frc_a_lvl | input | 1 | Force level for output A |
| frc_b_en | input | 1 | Force enable for output B |
| frc_b_lvl | input | 1 | Force level for output B |
| out_a | output | 1 | PWM output A (rising-slope pulse) |
| out_b | output | 1 | PWM output B (falling-slope pulse) |
| cnt | output | CNT_W | Current counter value |
| cnt_down | output | 1 | Counter direction, 1 = falling |
| tripped | output | 1 | Trip latch state |

## Verification
Some rules are checked by assertions on every cycle. These are the single counter step, the hold while disabled, sync and write loading, the latch setting on a trip, and the outputs going low on a trip. The assertions also check that release happens only on the edge after a rising-slope zero, and that a forced output follows its level. Other properties show only through whole scenarios, so the bench has to drive them. One is that output A is the first to pulse after recovery. Another is that a clear armed on a falling slope waits out the rest of that slope. A third is that a second trip silently cancels a pending release.

// File: rtl/pwm_pkg.sv
// Shared type for the up-down PWM block: the counter direction encoding.
package pwm_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/pwm_timebase.sv
// Symmetric up-down time-base counter.
// Does: counts 0..period..0 while enabled; sync loads phase (priority),
// a direct write loads a value and keeps direction.
// Assumes: phase and written values are normally <= period; an out-of-range
// value simply counts down toward zero.
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    input  logic             sync,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output cnt_dir_e         dir
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_nxt;
    cnt_dir_e         dir_nxt;

    // Next-state selection: sync, then write, then normal stepping.
    always_comb begin
        cnt_nxt = cnt;
        dir_nxt = dir;
        if (sync) begin
            cnt_nxt = phase;
            dir_nxt = DIR_UP;
        end else if (wr) begin
            cnt_nxt = wdata;
        end else if (en) begin
            if (dir == DIR_UP && cnt < period) begin
                cnt_nxt = cnt + ONE;
                dir_nxt = ((cnt + ONE) == period) ? DIR_DOWN : DIR_UP;
            end else if (cnt == ZERO) begin
                dir_nxt = DIR_UP;
            end else begin
                cnt_nxt = cnt - ONE;
                dir_nxt = (cnt == ONE) ? DIR_UP : DIR_DOWN;
            end
        end
    end

    // Counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
            dir <= DIR_UP;
        end else begin
            cnt <= cnt_nxt;
            dir <= dir_nxt;
        end
    end

    // R1: a free-running rising step adds exactly one
    a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync && !wr && dir == DIR_UP && cnt < period) |=> cnt == $past(cnt) + ONE);

    // R3: disabled counter holds value and direction
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sync && !wr) |=> ($stable(cnt) && $stable(dir)));

    // R4: sync loads phase and restarts rising
    a_r4_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (cnt == $past(phase) && dir == DIR_UP));

    // R5: direct write loads value, direction unchanged
    a_r5_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sync) |=> (cnt == $past(wdata) && dir == $past(dir)));
endmodule

// File: rtl/pwm_trip_latch.sv
// One-shot trip latch with deferred release.
// Does: a trip sets the latch and cancels any pending clear; a clear request
// while latched is held pending and releases the latch only at a rising-slope
// zero of the counter.
// Assumes: at_zero_up is computed from the registered counter state.
module pwm_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr_req,
    input  logic at_zero_up,
    output logic latched,
    output logic pending
);
    logic release_now;

    // Release fires only on a pending clear at the known counter point.
    always_comb release_now = pending && latched && at_zero_up && !trip;

    // Latch and pending-flag update; trip has top priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
            pending <= 1'b0;
        end else if (trip) begin
            latched <= 1'b1;
            pending <= 1'b0;
        end else if (release_now) begin
            latched <= 1'b0;
            pending <= 1'b0;
        end else if (clr_req && latched) begin
            pending <= 1'b1;
        end
    end

    // R6: a trip always leaves the latch set with nothing pending
    a_r6_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (latched && !pending));

    // R7: the latch falls only after a rising-slope zero
    a_r7_release_point: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !at_zero_up) |=> latched);

    // R8: without a pending clear the latch cannot fall
    a_r8_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !pending) |=> latched);
endmodule

// File: rtl/pwm_out_stage.sv
// Registered output stage for one PWM channel.
// Does: applies block (trip) > force > clear event > set event > hold.
// Assumes: set/clear events are single-cycle qualified by the caller.
module pwm_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic block,
    input  logic frc_en,
    input  logic frc_lvl,
    input  logic set_evt,
    input  logic clr_evt,
    output logic q
);
    // Output register with fixed priority of sources.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (block)    q <= 1'b0;
        else if (frc_en)   q <= frc_lvl;
        else if (clr_evt)  q <= 1'b0;
        else if (set_evt)  q <= 1'b1;
    end

    // R6: a blocked channel is low on the next cycle
    a_r6_block_low: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !q);

    // R9: an unblocked forced channel follows its level
    a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_en && !block) |=> q == $past(frc_lvl));
endmodule

// File: rtl/updown_pwm_trip.sv
// Up-down PWM channel pair with synchronized trip recovery.
// Does: A acts on rising-slope compare matches, B on falling-slope matches;
// a trip latch forces both low and is released only at a rising-slope zero.
// Assumes: all inputs are synchronous to clk.
module updown_pwm_trip
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] phase,
    input  logic             sync_ext,
    input  logic             sync_sw,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             trip_in,
    input  logic             trip_clr,
    input  logic             frc_a_en,
    input  logic             frc_a_lvl,
    input  logic             frc_b_en,
    input  logic             frc_b_lvl,
    output logic             out_a,
    output logic             out_b,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_down,
    output logic             tripped
);
    cnt_dir_e   dir;
    logic       pending;
    logic       block;
    logic       at_zero_up;
    logic [1:0] set_evt;
    logic [1:0] clr_evt;
    logic [1:0] frc_en;
    logic [1:0] frc_lvl;
    logic [1:0] q;

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(tb_en), .period(period), .phase(phase),
        .sync(sync_ext | sync_sw), .wr(cnt_wr), .wdata(cnt_wdata),
        .cnt(cnt), .dir(dir)
    );

    pwm_trip_latch u_trip (
        .clk(clk), .rst_n(rst_n), .trip(trip_in), .clr_req(trip_clr),
        .at_zero_up(at_zero_up), .latched(tripped), .pending(pending)
    );

    // Compare-event decode and block condition from registered state.
    always_comb begin
        at_zero_up = (cnt == '0) && (dir == DIR_UP);
        block      = trip_in | tripped;
        set_evt[0] = (cnt == cmp) && (dir == DIR_UP);
        clr_evt[0] = (cnt == period);
        set_evt[1] = (cnt == cmp) && (dir == DIR_DOWN);
        clr_evt[1] = (cnt == '0);
        frc_en     = {frc_b_en, frc_a_en};
        frc_lvl    = {frc_b_lvl, frc_a_lvl};
    end

    // One output stage per channel.
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        pwm_out_stage u_out (
            .clk(clk), .rst_n(rst_n), .block(block),
            .frc_en(frc_en[ch]), .frc_lvl(frc_lvl[ch]),
            .set_evt(set_evt[ch]), .clr_evt(clr_evt[ch]), .q(q[ch])
        );
    end

    assign out_a    = q[0];
    assign out_b    = q[1];
    assign cnt_down = (dir == DIR_DOWN);

    // R2: output A never rises while the counter is falling past a match
    a_r2_a_rises_on_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!block && !frc_a_en && dir == DIR_DOWN && cnt != cmp && !out_a) |=> !out_a);

    // R7: outputs are still low right after a release
    a_r7_low_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tripped) |-> (!out_a && !out_b));
endmodule

// File: tb/updown_pwm_trip_test.sv
`timescale 1ns/1ps
module updown_pwm_trip_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tb_en = 1'b0;
    logic [W-1:0] period = '0, cmp = '0, phase = '0, cnt_wdata = '0;
    logic         sync_ext = 1'b0, sync_sw = 1'b0, cnt_wr = 1'b0;
    logic         trip_in = 1'b0, trip_clr = 1'b0;
    logic         frc_a_en = 1'b0, frc_a_lvl = 1'b0, frc_b_en = 1'b0, frc_b_lvl = 1'b0;
    logic         out_a, out_b, cnt_down, tripped;
    logic [W-1:0] cnt;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    updown_pwm_trip #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .period(period), .cmp(cmp),
        .phase(phase), .sync_ext(sync_ext), .sync_sw(sync_sw), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .trip_in(trip_in), .trip_clr(trip_clr),
        .frc_a_en(frc_a_en), .frc_a_lvl(frc_a_lvl), .frc_b_en(frc_b_en),
        .frc_b_lvl(frc_b_lvl), .out_a(out_a), .out_b(out_b), .cnt(cnt),
        .cnt_down(cnt_down), .tripped(tripped)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Behavioural reference model, updated on each rising edge.
    int m_cnt, m_down, m_lat, m_pend, m_a, m_b;
    int oc, od, ol, op, blk, rel;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_down = 0; m_lat = 0; m_pend = 0; m_a = 0; m_b = 0;
        end else begin
            oc = m_cnt; od = m_down; ol = m_lat; op = m_pend;
            blk = (trip_in || ol) ? 1 : 0;
            if (blk != 0) m_a = 0;
            else if (frc_a_en) m_a = int'(frc_a_lvl);
            else if (oc == int'(period)) m_a = 0;
            else if (od == 0 && oc == int'(cmp)) m_a = 1;
            if (blk != 0) m_b = 0;
            else if (frc_b_en) m_b = int'(frc_b_lvl);
            else if (oc == 0) m_b = 0;
            else if (od == 1 && oc == int'(cmp)) m_b = 1;
            rel = (op == 1 && ol == 1 && oc == 0 && od == 0 && !trip_in) ? 1 : 0;
            if (trip_in) begin m_lat = 1; m_pend = 0; end
            else if (rel != 0) begin m_lat = 0; m_pend = 0; end
            else if (trip_clr && ol == 1) m_pend = 1;
            if (sync_ext || sync_sw) begin m_cnt = int'(phase); m_down = 0; end
            else if (cnt_wr) m_cnt = int'(cnt_wdata);
            else if (tb_en) begin
                if (od == 0 && oc < int'(period)) begin
                    m_cnt = oc + 1; m_down = (oc + 1 == int'(period)) ? 1 : 0;
                end else if (oc == 0) m_down = 0;
                else begin m_cnt = oc - 1; m_down = (oc != 1) ? 1 : 0; end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    task automatic compare();
        chk(int'(cnt) == m_cnt, "R1 count", int'(cnt), m_cnt);
        chk(int'(cnt_down) == m_down, "R1 dir", int'(cnt_down), m_down);
        chk(int'(out_a) == m_a, "R2 out_a", int'(out_a), m_a);
        chk(int'(out_b) == m_b, "R2 out_b", int'(out_b), m_b);
        chk(int'(tripped) == m_lat, "R6 latch", int'(tripped), m_lat);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    int held, guard, first;
    bit pa, pb;
    initial begin
        run(3);
        chk(cnt == '0 && !out_a && !out_b && !tripped, "R1 reset", int'(cnt), 0);
        rst_n = 1'b1;
        period = 16'd6; cmp = 16'd2; tb_en = 1'b1;
        run(30);

        // R3: pause holds; resume from held value without phase reload
        phase = 16'd5;
        tb_en = 1'b0; held = int'(cnt);
        run(5);
        chk(int'(cnt) == held, "R3 hold", int'(cnt), held);
        tb_en = 1'b1;
        tick();
        chk(int'(cnt) != 5 || held == 4 || held == 6, "R3 no reload", int'(cnt), held);
        run(3);

        // R4: sync load while disabled
        tb_en = 1'b0; phase = 16'd3; sync_ext = 1'b1;
        tick();
        sync_ext = 1'b0;
        chk(int'(cnt) == 3 && !cnt_down, "R4 sync", int'(cnt), 3);
        tb_en = 1'b1;
        run(10);

        // R5: write, then write together with sync
        cnt_wr = 1'b1; cnt_wdata = 16'd5;
        tick();
        cnt_wr = 1'b0;
        chk(int'(cnt) == 5, "R5 write", int'(cnt), 5);
        run(4);
        cnt_wr = 1'b1; cnt_wdata = 16'd1; sync_sw = 1'b1; phase = 16'd4;
        tick();
        cnt_wr = 1'b0; sync_sw = 1'b0;
        chk(int'(cnt) == 4, "R5 sync wins", int'(cnt), 4);
        run(14);

        // R6: trip on the falling slope
        guard = 0;
        while (!(cnt_down && cnt == 16'd4) && guard < 20) begin tick(); guard++; end
        trip_in = 1'b1;
        tick();
        trip_in = 1'b0;
        chk(tripped && !out_a && !out_b, "R6 trip", int'(out_a) + int'(out_b), 0);
        run(5);
        // R7: clear on falling slope must wait for the zero point
        guard = 0;
        while (!(cnt_down && cnt == 16'd4) && guard < 20) begin tick(); guard++; end
        trip_clr = 1'b1;
        tick();
        trip_clr = 1'b0;
        chk(tripped == 1'b1, "R7 deferred", int'(tripped), 1);
        guard = 0;
        while (tripped && guard < 30) begin
            held = int'(cnt);
            tick(); guard++;
        end
        chk(held == 0 && int'(cnt) == 1, "R7 release point", held, 0);
        // R10: first rising output after release is A
        first = 0; pa = out_a; pb = out_b; guard = 0;
        while (first == 0 && guard < 20) begin
            tick(); guard++;
            if (out_a && !pa) first = 1;
            else if (out_b && !pb) first = 2;
            pa = out_a; pb = out_b;
        end
        chk(first == 1, "R10 first pulse A", first, 1);
        run(10);

        // R8: trip while a clear is pending cancels it
        trip_in = 1'b1; tick(); trip_in = 1'b0;
        guard = 0;
        while (!(!cnt_down && cnt == 16'd2) && guard < 20) begin tick(); guard++; end
        trip_clr = 1'b1; tick(); trip_clr = 1'b0;
        trip_in = 1'b1; tick(); trip_in = 1'b0;
        run(20);
        chk(tripped == 1'b1, "R8 cancel", int'(tripped), 1);
        trip_in = 1'b1; trip_clr = 1'b1; tick(); trip_in = 1'b0; trip_clr = 1'b0;
        run(20);
        chk(tripped == 1'b1, "R8 same cycle", int'(tripped), 1);
        trip_clr = 1'b1; tick(); trip_clr = 1'b0;
        run(20);
        chk(tripped == 1'b0, "R7 released", int'(tripped), 0);

        // R9: force overrides compare; trip overrides force
        frc_a_en = 1'b1; frc_a_lvl = 1'b1; frc_b_en = 1'b1; frc_b_lvl = 1'b0;
        run(14);
        chk(out_a && !out_b, "R9 force", int'(out_a), 1);
        trip_in = 1'b1; tick(); trip_in = 1'b0;
        chk(!out_a, "R9 trip over force", int'(out_a), 0);
        frc_a_en = 1'b0; frc_b_en = 1'b0;
        trip_clr = 1'b1; tick(); trip_clr = 1'b0;
        run(20);

        // R1/R2: other period and compare settings
        period = 16'd3; cmp = 16'd1;
        run(20);
        period = 16'd0;
        run(8);
        chk(cnt == '0, "R1 period zero", int'(cnt), 0);
        finish_run();
    end
endmodule